// File: doc/BRIEF.md
# UART Prioritized Interrupt Status Unit

This block gathers every interrupt cause of a single-channel UART and presents only the most urgent enabled one as a six-bit status value. The same value drives one interrupt request line. The surrounding UART supplies event strobes and levels from its receive and transmit FIFOs, line-status and modem-status logic, flow-control pins, character detectors and sleep controller. It also supplies read and write strobes for the registers whose access clears a cause. Each cause keeps its own pending flag with its own set and clear rule. Lower-priority causes stay queued while a higher one is reported.

The receive-timeout cause comes from a small state machine. It counts bit-time ticks while the receive FIFO holds data and nothing else happens. State TMO_IDLE (FIFO empty) moves to TMO_COUNT when data is present. TMO_COUNT returns to TMO_IDLE when the FIFO empties. It restarts its count in place on a received character or a holding-register read, and moves to TMO_FIRED once the idle window has elapsed. TMO_FIRED returns to TMO_COUNT on a holding-register read, or to TMO_IDLE if the FIFO empties. The window is 4 character times plus 12 bit times, that is 4*CHAR_BITS+12 ticks.

Top module: `uart_irq_status`

## Requirements
- R1: Priority levels, highest first: 0 line status, 1 receive timeout, 2 receive ready, 3 transmit ready, 4 modem status, 5 Xoff/special character, 6 flow control, 7 wake-up. `isr_val` equals {2'b00, level[2:0], 1'b0} for the highest enabled pending level. It equals 6'b000001 when none is pending, which includes the state right after reset. `src_en[k]` enables level k.
- R2: Any bit of the `lsr_flags` strobe sets the line-status cause, and an `lsr_rd` clears it. While `fifo_err_lvl` is high the cause stays pending despite `lsr_rd`.
- R3: The receive-ready cause follows `rx_at_trig` directly: it is pending exactly while that level is high.
- R4: With `rx_nonempty` high, the timeout cause becomes pending after 4*CHAR_BITS+12 `bit_tick` pulses counted from entry to TMO_COUNT or from the last `rx_char`/`rhr_rd`. It clears on `rhr_rd` and never fires while the FIFO is empty.
- R5: A rising edge of `tx_room` sets the transmit cause. `thr_wr` clears it, and so does `isr_rd` while level 3 is the reported level. A status read that reports another level leaves it pending.
- R6: Any `msr_delta` bit sets the modem cause. A rising edge of `cts_n_pin` with `auto_cts_en`, or of `rts_n_pin` with `auto_rts_en`, sets a flow cause. `msr_rd` clears all three.
- R7: `xoff_det` sets the Xoff cause and `xon_det` clears it. `spec_det` sets the special-character cause and the next `rx_char` clears it. `isr_rd` while level 5 is reported clears both.
- R8: The CTS flow cause is reported only when `cts_irq_en` and `enh_mode` are both high. The RTS flow cause is gated by `src_en[6]`.
- R9: `wake_evt` sets the wake-up cause, and `isr_rd` while level 7 is reported clears it.
- R10: A set and a clear of the same cause in one cycle leave it pending. During a status read, `isr_val` shows the state from before that read's clears.
- R11: `irq` is high exactly when some enabled cause is pending, which is exactly when `isr_val[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 8 | Per-level report enable |
| cts_irq_en | input | 1 | CTS flow interrupt enable |
| enh_mode | input | 1 | Enhanced-feature mode; required for the CTS enable |
| auto_cts_en | input | 1 | Automatic CTS flow control active |
| auto_rts_en | input | 1 | Automatic RTS flow control active |
| lsr_flags | input | 4 | Line error/break strobes |
| fifo_err_lvl | input | 1 | Errored characters still in receive FIFO |
| rx_at_trig | input | 1 | Receive FIFO at or above trigger level |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| rx_char | input | 1 | Character received strobe |
| bit_tick | input | 1 | One pulse per bit time |
| tx_room | input | 1 | Transmit FIFO at trigger level or empty |
| msr_delta | input | 4 | Modem-status change strobes |
| cts_n_pin | input | 1 | CTS pin level |
| rts_n_pin | input | 1 | RTS pin level |
| xoff_det | input | 1 | Xoff character detected |
| xon_det | input | 1 | Xon character detected |
| spec_det | input | 1 | Special character detected |
| wake_evt | input | 1 | Exit from sleep mode |
| isr_rd | input | 1 | Status register read strobe |
| lsr_rd | input | 1 | Line-status register read strobe |
| msr_rd | input | 1 | Modem-status register read strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| isr_val | output | 6 | Encoded highest pending interrupt |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all 256 combinations of pending levels and all 256 enable masks. A priority encoder that scanned in the wrong direction, or ignored a mask bit, reports the wrong level there. It then services a full queue one source at a time. That sequence catches a modem-status read that failed to drop the flow cause, and a status read that cleared an unreported transmit cause. The timeout is probed one tick short of the window and again after a mid-window character. An off-by-one counter fires early, and a counter that ignored the restart fires early after the character. Same-cycle set/clear collisions are driven on purpose, where a clear-priority latch would silently lose an event.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NUM_LVL   = 8;
    localparam int LVL_W     = $clog2(NUM_LVL);
    localparam int CODE_W    = 6;
    localparam int LSR_SRC_W = 4;
    localparam int MSR_SRC_W = 4;

    // priority levels, 0 = most urgent
    localparam int L_LSR   = 0;
    localparam int L_RXTMO = 1;
    localparam int L_RXRDY = 2;
    localparam int L_TXRDY = 3;
    localparam int L_MODEM = 4;
    localparam int L_XCHAR = 5;
    localparam int L_FLOW  = 6;
    localparam int L_WAKE  = 7;

    // latched pending flags
    localparam int NUM_PL = 8;
    localparam int P_LSR  = 0;
    localparam int P_TX   = 1;
    localparam int P_MSR  = 2;
    localparam int P_XOFF = 3;
    localparam int P_SPEC = 4;
    localparam int P_CTS  = 5;
    localparam int P_RTS  = 6;
    localparam int P_WAKE = 7;

    localparam logic [CODE_W-1:0] CODE_NONE = 6'b000001;

    typedef enum logic [1:0] {
        TMO_IDLE  = 2'd0,
        TMO_COUNT = 2'd1,
        TMO_FIRED = 2'd2
    } tmo_state_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_o[g] <= 1'b0;
            else if (set_i[g])
                pend_o[g] <= 1'b1;
            else if (clr_i[g])
                pend_o[g] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_o[g]); // R10
    end
endmodule

// File: rtl/irq_rx_timeout.sv
module irq_rx_timeout
    import uart_irq_pkg::*;
#(
    parameter int CHAR_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_nonempty_i,
    input  logic rx_char_i,
    input  logic rhr_rd_i,
    input  logic bit_tick_i,
    output logic fired_o
);
    localparam int LIMIT = 4 * CHAR_BITS + 12;
    localparam int CNT_W = $clog2(LIMIT + 1);

    tmo_state_e        state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic              restart, at_end;

    assign restart = rx_char_i | rhr_rd_i;
    assign at_end  = bit_tick_i && (cnt == CNT_W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TMO_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TMO_IDLE:  if (rx_nonempty_i) state_nx = TMO_COUNT;
            TMO_COUNT: begin
                if (!rx_nonempty_i)          state_nx = TMO_IDLE;
                else if (!restart && at_end) state_nx = TMO_FIRED;
            end
            TMO_FIRED: begin
                if (!rx_nonempty_i) state_nx = TMO_IDLE;
                else if (rhr_rd_i)  state_nx = TMO_COUNT;
            end
            default:   state_nx = TMO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (state != TMO_COUNT || restart || at_end)
            cnt <= '0;
        else if (bit_tick_i)
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        fired_o = (state == TMO_FIRED);
    end

    AST_TMO_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(LIMIT)); // R4
    AST_TMO_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TMO_IDLE && !rx_nonempty_i) |=> state == TMO_IDLE); // R4
    AST_TMO_RHR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TMO_FIRED && rhr_rd_i) |=> !fired_o); // R4
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
#(
    parameter int N  = NUM_LVL,
    parameter int LW = LVL_W,
    parameter int CW = CODE_W
) (
    input  logic [N-1:0]  act_i,
    output logic          found_o,
    output logic [LW-1:0] lvl_o,
    output logic [CW-1:0] code_o
);
    always_comb begin
        found_o = 1'b0;
        lvl_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act_i[i]) begin
                found_o = 1'b1;
                lvl_o   = LW'(i);
            end
        end
        code_o = found_o ? {{(CW - LW - 1){1'b0}}, lvl_o, 1'b0} : CW'(CODE_NONE);
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int CHAR_BITS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LVL-1:0]   src_en,
    input  logic                 cts_irq_en,
    input  logic                 enh_mode,
    input  logic                 auto_cts_en,
    input  logic                 auto_rts_en,
    input  logic [LSR_SRC_W-1:0] lsr_flags,
    input  logic                 fifo_err_lvl,
    input  logic                 rx_at_trig,
    input  logic                 rx_nonempty,
    input  logic                 rx_char,
    input  logic                 bit_tick,
    input  logic                 tx_room,
    input  logic [MSR_SRC_W-1:0] msr_delta,
    input  logic                 cts_n_pin,
    input  logic                 rts_n_pin,
    input  logic                 xoff_det,
    input  logic                 xon_det,
    input  logic                 spec_det,
    input  logic                 wake_evt,
    input  logic                 isr_rd,
    input  logic                 lsr_rd,
    input  logic                 msr_rd,
    input  logic                 rhr_rd,
    input  logic                 thr_wr,
    output logic [CODE_W-1:0]    isr_val,
    output logic                 irq
);
    logic [NUM_PL-1:0]  pl_set, pl_clr, pend;
    logic [NUM_LVL-1:0] act;
    logic               tx_room_q, cts_q, rts_q;
    logic               tmo_fired, found;
    logic [LVL_W-1:0]   cur_lvl;
    logic               rd_tx, rd_xchar, rd_wake;

    // edge history; pins idle high so a rise needs a prior low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_room_q <= 1'b0;
            cts_q     <= 1'b1;
            rts_q     <= 1'b1;
        end else begin
            tx_room_q <= tx_room;
            cts_q     <= cts_n_pin;
            rts_q     <= rts_n_pin;
        end
    end

    // status read only clears the level it reports this cycle
    assign rd_tx    = isr_rd && found && (cur_lvl == LVL_W'(L_TXRDY));
    assign rd_xchar = isr_rd && found && (cur_lvl == LVL_W'(L_XCHAR));
    assign rd_wake  = isr_rd && found && (cur_lvl == LVL_W'(L_WAKE));

    always_comb begin
        pl_set = '0;
        pl_clr = '0;
        pl_set[P_LSR]  = (|lsr_flags) | fifo_err_lvl;
        pl_clr[P_LSR]  = lsr_rd;
        pl_set[P_TX]   = tx_room & ~tx_room_q;
        pl_clr[P_TX]   = thr_wr | rd_tx;
        pl_set[P_MSR]  = |msr_delta;
        pl_clr[P_MSR]  = msr_rd;
        pl_set[P_XOFF] = xoff_det;
        pl_clr[P_XOFF] = xon_det | rd_xchar;
        pl_set[P_SPEC] = spec_det;
        pl_clr[P_SPEC] = rx_char | rd_xchar;
        pl_set[P_CTS]  = auto_cts_en & cts_n_pin & ~cts_q;
        pl_clr[P_CTS]  = msr_rd;
        pl_set[P_RTS]  = auto_rts_en & rts_n_pin & ~rts_q;
        pl_clr[P_RTS]  = msr_rd;
        pl_set[P_WAKE] = wake_evt;
        pl_clr[P_WAKE] = rd_wake;
    end

    irq_pend_bank #(.N(NUM_PL)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pl_set),
        .clr_i  (pl_clr),
        .pend_o (pend)
    );

    irq_rx_timeout #(.CHAR_BITS(CHAR_BITS)) u_tmo (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_nonempty_i (rx_nonempty),
        .rx_char_i     (rx_char),
        .rhr_rd_i      (rhr_rd),
        .bit_tick_i    (bit_tick),
        .fired_o       (tmo_fired)
    );

    always_comb begin
        act          = '0;
        act[L_LSR]   = pend[P_LSR] & src_en[L_LSR];
        act[L_RXTMO] = tmo_fired & src_en[L_RXTMO];
        act[L_RXRDY] = rx_at_trig & src_en[L_RXRDY];
        act[L_TXRDY] = pend[P_TX] & src_en[L_TXRDY];
        act[L_MODEM] = pend[P_MSR] & src_en[L_MODEM];
        act[L_XCHAR] = (pend[P_XOFF] | pend[P_SPEC]) & src_en[L_XCHAR];
        act[L_FLOW]  = (pend[P_RTS] & src_en[L_FLOW])
                     | (pend[P_CTS] & cts_irq_en & enh_mode);
        act[L_WAKE]  = pend[P_WAKE] & src_en[L_WAKE];
    end

    irq_prio_enc #(.N(NUM_LVL), .LW(LVL_W), .CW(CODE_W)) u_enc (
        .act_i   (act),
        .found_o (found),
        .lvl_o   (cur_lvl),
        .code_o  (isr_val)
    );

    assign irq = |act;

    AST_NONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !isr_val[0]); // R11
    AST_LSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_err_lvl |=> pend[P_LSR]); // R2
    AST_XON_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (xon_det && !xoff_det) |=> !pend[P_XOFF]); // R7
    AST_MSR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !(|msr_delta)) |=> !pend[P_MSR]); // R6
    AST_TX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && pend[P_TX] && act[L_LSR] && !thr_wr) |=> pend[P_TX]); // R5
endmodule

// File: tb/tb_uart_irq_status.sv
module tb_uart_irq_status;
    localparam int CB  = 10;
    localparam int LIM = 4 * CB + 12;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [7:0] src_en;
    logic       cts_irq_en, enh_mode, auto_cts_en, auto_rts_en;
    logic [3:0] lsr_flags, msr_delta;
    logic       fifo_err_lvl, rx_at_trig, rx_nonempty, rx_char, bit_tick, tx_room;
    logic       cts_n_pin, rts_n_pin, xoff_det, xon_det, spec_det, wake_evt;
    logic       isr_rd, lsr_rd, msr_rd, rhr_rd, thr_wr;
    logic [5:0] isr_val;
    logic       irq;
    int errs = 0, checks = 0;

    uart_irq_status #(.CHAR_BITS(CB)) dut (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .cts_irq_en(cts_irq_en),
        .enh_mode(enh_mode), .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
        .lsr_flags(lsr_flags), .fifo_err_lvl(fifo_err_lvl), .rx_at_trig(rx_at_trig),
        .rx_nonempty(rx_nonempty), .rx_char(rx_char), .bit_tick(bit_tick),
        .tx_room(tx_room), .msr_delta(msr_delta), .cts_n_pin(cts_n_pin),
        .rts_n_pin(rts_n_pin), .xoff_det(xoff_det), .xon_det(xon_det),
        .spec_det(spec_det), .wake_evt(wake_evt), .isr_rd(isr_rd), .lsr_rd(lsr_rd),
        .msr_rd(msr_rd), .rhr_rd(rhr_rd), .thr_wr(thr_wr), .isr_val(isr_val), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(string r, logic [5:0] a, logic [5:0] e);
        checks++;
        if (a !== e) begin
            errs++;
            $display("FAIL %s actual=%b expected=%b", r, a, e);
        end
    endtask

    // lvl < 0 means nothing pending
    task automatic expect_lvl(string r, int lvl);
        logic [5:0] e;
        #1;
        e = (lvl < 0) ? 6'b000001 : {2'b00, 3'(lvl), 1'b0};
        chk({r, " isr_val"}, isr_val, e);
        chk({r, " irq"}, {5'b0, irq}, {5'b0, (lvl >= 0)});
    endtask

    task automatic idle_inputs();
        src_en = 8'hFF; cts_irq_en = 0; enh_mode = 0; auto_cts_en = 0; auto_rts_en = 0;
        lsr_flags = 0; msr_delta = 0; fifo_err_lvl = 0; rx_at_trig = 0; rx_nonempty = 0;
        rx_char = 0; bit_tick = 0; tx_room = 0; cts_n_pin = 1; rts_n_pin = 1;
        xoff_det = 0; xon_det = 0; spec_det = 0; wake_evt = 0;
        isr_rd = 0; lsr_rd = 0; msr_rd = 0; rhr_rd = 0; thr_wr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; idle_inputs(); cyc(); cyc(); rst_n = 1; cyc();
    endtask

    // bit k of p makes level k pending
    task automatic set_pattern(int p);
        do_reset();
        auto_rts_en = 1;
        lsr_flags = p[0] ? 4'b0100 : 4'b0;
        rx_nonempty = p[1];
        rx_at_trig = p[2];
        tx_room = p[3];
        msr_delta = p[4] ? 4'b0001 : 4'b0;
        xoff_det = p[5];
        rts_n_pin = !p[6];
        wake_evt = p[7];
        cyc();
        lsr_flags = 0; msr_delta = 0; xoff_det = 0; wake_evt = 0; rts_n_pin = 1;
        cyc();
        if (p[1]) begin
            bit_tick = 1;
            repeat (LIM) cyc();
            bit_tick = 0;
        end
    endtask

    function automatic int lowest(int v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        do_reset();
        expect_lvl("R1 reset", -1);

        // R1 priority sweep over every pending combination
        for (int p = 0; p < 256; p++) begin
            set_pattern(p);
            expect_lvl("R1 pattern", lowest(p));
        end
        // R1 enable mask sweep with all levels pending
        set_pattern(255);
        for (int e = 0; e < 256; e++) begin
            src_en = 8'(e);
            expect_lvl("R1 mask", lowest(e));
        end

        // service a full queue in order
        set_pattern(255);
        expect_lvl("R1 full", 0);
        lsr_rd = 1; cyc(); lsr_rd = 0;
        expect_lvl("R2 lsr read", 1);
        rhr_rd = 1; cyc(); rhr_rd = 0;
        expect_lvl("R4 rhr read", 2);
        rx_at_trig = 0;
        expect_lvl("R3 below trigger", 3);
        isr_rd = 1; cyc(); isr_rd = 0;
        expect_lvl("R5 status read", 4);
        msr_rd = 1; cyc(); msr_rd = 0;
        expect_lvl("R6 msr read drops modem and flow", 5);
        isr_rd = 1; cyc(); isr_rd = 0;
        expect_lvl("R7 status read", 7);
        isr_rd = 1; cyc(); isr_rd = 0;
        expect_lvl("R9 status read", -1);

        // R2 FIFO error keeps line status pending
        do_reset();
        fifo_err_lvl = 1; cyc();
        lsr_rd = 1; cyc(); lsr_rd = 0;
        expect_lvl("R2 err held", 0);
        fifo_err_lvl = 0; lsr_rd = 1; cyc(); lsr_rd = 0;
        expect_lvl("R2 err gone", -1);

        // R3 level follows
        rx_at_trig = 1;
        expect_lvl("R3 at trigger", 2);
        rx_at_trig = 0;

        // R4 timeout window
        do_reset();
        rx_nonempty = 1; cyc();
        bit_tick = 1; repeat (LIM - 1) cyc(); bit_tick = 0;
        expect_lvl("R4 one short", -1);
        rx_char = 1; cyc(); rx_char = 0;
        bit_tick = 1; repeat (LIM - 1) cyc(); bit_tick = 0;
        expect_lvl("R4 restart by char", -1);
        bit_tick = 1; cyc(); bit_tick = 0;
        expect_lvl("R4 fires", 1);
        rhr_rd = 1; cyc(); rhr_rd = 0;
        expect_lvl("R4 rhr clears", -1);
        rx_nonempty = 0; cyc();
        bit_tick = 1; repeat (LIM + 2) cyc(); bit_tick = 0;
        expect_lvl("R4 empty never fires", -1);

        // R5 unreported status read keeps transmit
        do_reset();
        tx_room = 1; cyc();
        expect_lvl("R5 rise sets", 3);
        lsr_flags = 4'b0001; cyc(); lsr_flags = 0;
        expect_lvl("R5 lsr above", 0);
        isr_rd = 1; cyc(); isr_rd = 0;
        lsr_rd = 1; cyc(); lsr_rd = 0;
        expect_lvl("R5 tx survives other read", 3);
        thr_wr = 1; cyc(); thr_wr = 0;
        expect_lvl("R5 thr write clears", -1);
        cyc();
        expect_lvl("R5 steady level no reset", -1);

        // R7 Xoff and special character
        do_reset();
        xoff_det = 1; cyc(); xoff_det = 0;
        expect_lvl("R7 xoff", 5);
        xon_det = 1; cyc(); xon_det = 0;
        expect_lvl("R7 xon clears", -1);
        spec_det = 1; cyc(); spec_det = 0;
        expect_lvl("R7 special", 5);
        rx_char = 1; cyc(); rx_char = 0;
        expect_lvl("R7 next char clears", -1);

        // R8 CTS gating
        do_reset();
        auto_cts_en = 1; cts_irq_en = 1;
        cts_n_pin = 0; cyc(); cts_n_pin = 1; cyc();
        expect_lvl("R8 no enhanced mode", -1);
        enh_mode = 1;
        expect_lvl("R8 enhanced mode", 6);
        msr_rd = 1; cyc(); msr_rd = 0;
        expect_lvl("R6 msr read clears cts", -1);
        auto_cts_en = 0;
        cts_n_pin = 0; cyc(); cts_n_pin = 1; cyc();
        expect_lvl("R6 no auto cts", -1);

        // R9 wake-up and R10 collisions
        do_reset();
        wake_evt = 1; cyc(); wake_evt = 0;
        expect_lvl("R9 wake", 7);
        isr_rd = 1; wake_evt = 1;
        expect_lvl("R10 value during read", 7);
        cyc(); isr_rd = 0; wake_evt = 0;
        expect_lvl("R10 wake set wins", 7);
        isr_rd = 1; cyc(); isr_rd = 0;
        expect_lvl("R9 wake cleared", -1);
        msr_delta = 4'b0010; cyc(); msr_delta = 0;
        expect_lvl("R6 modem", 4);
        msr_rd = 1; msr_delta = 4'b0100; cyc(); msr_rd = 0; msr_delta = 0;
        expect_lvl("R10 modem set wins", 4);
        msr_rd = 1; cyc(); msr_rd = 0;
        expect_lvl("R11 all idle", -1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule